// File: doc/BRIEF.md
# Token-Ring Zero-Suppressed Serial Readout Controller

This block decides when one chip may talk on a serial data line shared by a daisy chain of up to 256 chips, and what it sends while it may. After digitisation the chip holds between zero and sixteen event records in a local store. The controller sits idle until the token arrives on `token_in`. A chip with nothing stored forwards the token on the next clock and never drives the line. A chip with data drives the line for one contiguous burst, then releases it and forwards the token one cycle later.

A burst has two parts. First comes a header: the 8-bit node identifier, then the 5-bit event count. Then the records follow, one after another, in store-address order, each 34 bits wide. All fields are sent most significant bit first, at one bit per clock. The controller reads the record store through a synchronous port with one cycle of read latency. The store itself is outside the block.

Top module: `tokring_readout`

## Requirements
- R1: While reset is high, and on the first cycle after it, `bus_oe`, `xmit_busy`, `token_out` and `bus_data` are all 0.
- R2: When `token_in` is sampled high in idle with `ev_count` = 0, `token_out` is high for exactly the next cycle, and `bus_oe` stays low.
- R3: When `token_in` is sampled high in idle with `ev_count` > 0, `bus_oe` rises on the next cycle. The first 13 bits sent are `node_id[7:0]` followed by the 5-bit latched count, each most significant bit first.
- R4: After the header, the records at store addresses 0 to n-1 are sent in address order. Each record is 34 bits sent most significant bit first: coarse bunch-crossing tag [33:26], fine time [25:14], charge [13:2], gain select [1], trigger status [0].
- R5: `bus_oe` stays high for exactly 13 + 34·n consecutive cycles, where n is the latched count. `xmit_busy` equals `bus_oe` on every cycle.
- R6: `bus_oe` falls one cycle before `token_out` rises. `token_out` is a one-cycle pulse and is never high while `bus_oe` is high.
- R7: `bus_data` is 0 on every cycle in which `bus_oe` is low.
- R8: The count is latched when the token is accepted, and later changes of `ev_count` have no effect on that burst. A count above 16 is clamped to 16, both in the header and in the number of records sent.
- R9: A `token_in` pulse that arrives while a burst or a token hand-off is under way is ignored. It produces no extra header, no extra bits and no extra `token_out` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| token_in | input | 1 | Token arriving from the previous chip, one-cycle pulse |
| node_id | input | 8 | This chip's identifier on the shared line |
| ev_count | input | 5 | Number of records held in the store |
| rec_addr | output | 4 | Record store read address |
| rec_data | input | 34 | Record store read data, valid one cycle after `rec_addr` |
| bus_data | output | 1 | Serial data onto the shared line |
| bus_oe | output | 1 | Drive enable for the shared line |
| xmit_busy | output | 1 | High from the first bit sent to the last |
| token_out | output | 1 | Token passed to the next chip, one-cycle pulse |

## Verification
Two events can coincide. The first is a fresh `token_in` pulse landing while the chip is still sending or passing the token on. The second is a change of `ev_count` arriving in the middle of a burst, while the count is being compared to decide whether another record follows. The bench provokes both by pulsing `token_in` again and rewriting `ev_count` partway through a burst. The scoreboard then requires that the bit stream still matches exactly the header and the records expected from the latched count, that `bus_oe` stays high for the predicted length, and that exactly one `token_out` pulse appears, two cycles after the last driven bit.

// File: rtl/tokring_pkg.sv
package tokring_pkg;
  localparam int ID_BITS     = 8;
  localparam int COARSE_BITS = 8;
  localparam int FINE_BITS   = 12;
  localparam int CHARGE_BITS = 12;
  localparam int MAX_EVENTS  = 16;

  typedef struct packed {
    logic [COARSE_BITS-1:0] coarse;
    logic [FINE_BITS-1:0]   fine;
    logic [CHARGE_BITS-1:0] charge;
    logic                   gain_sel;
    logic                   trig_stat;
  } event_rec_t;

  localparam int REC_BITS = $bits(event_rec_t);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_PASS} tr_state_e;
endpackage

// File: rtl/tokring_shifter.sv
module tokring_shifter #(
  parameter int SW    = 34,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SW-1:0]    load_word,
  input  logic [LEN_W-1:0] load_last_idx,
  input  logic             shift_en,
  output logic             msb,
  output logic             word_end
);
  logic [SW-1:0]    sreg;
  logic [LEN_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      left <= '0;
    end else if (load) begin
      sreg <= load_word;
      left <= load_last_idx;
    end else if (shift_en) begin
      sreg <= sreg << 1;
      if (left != '0) left <= left - 1'b1;
    end
  end

  assign msb      = sreg[SW-1];
  assign word_end = (left == '0);

  // R5: a word never claims more bits than the shifter holds
  a_r5_len_bound: assert property (@(posedge clk) disable iff (rst)
    left <= LEN_W'(SW-1));
endmodule

// File: rtl/tokring_seq.sv
module tokring_seq
  import tokring_pkg::*;
#(
  parameter int MAX_EV = 16,
  parameter int CNT_W  = 5,
  parameter int AW     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             token_in,
  input  logic [CNT_W-1:0] ev_count,
  input  logic             word_end,
  output logic             ld_header,
  output logic             ld_record,
  output logic [CNT_W-1:0] cnt_latched,
  output logic [CNT_W-1:0] cnt_clamped,
  output logic [AW-1:0]    rec_addr,
  output logic             drive,
  output logic             tok_out
);
  tr_state_e        state;
  logic [CNT_W-1:0] cnt_q, sent_q;
  logic [AW-1:0]    addr_q;
  logic             drive_q, tok_q;

  assign cnt_clamped = (ev_count > CNT_W'(MAX_EV)) ? CNT_W'(MAX_EV) : ev_count;
  assign ld_header   = (state == ST_IDLE) && token_in && (ev_count != '0);
  assign ld_record   = (state == ST_SEND) && word_end && (sent_q != cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt_q   <= '0;
      sent_q  <= '0;
      addr_q  <= '0;
      drive_q <= 1'b0;
      tok_q   <= 1'b0;
    end else begin
      tok_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (token_in) begin
            if (ev_count == '0) begin
              tok_q <= 1'b1;
            end else begin
              cnt_q   <= cnt_clamped;
              sent_q  <= '0;
              addr_q  <= '0;
              drive_q <= 1'b1;
              state   <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (word_end) begin
            if (sent_q != cnt_q) begin
              sent_q <= sent_q + 1'b1;
              addr_q <= addr_q + 1'b1;
            end else begin
              drive_q <= 1'b0;
              addr_q  <= '0;
              state   <= ST_PASS;
            end
          end
        end
        ST_PASS: begin
          tok_q <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cnt_latched = cnt_q;
  assign rec_addr    = addr_q;
  assign drive       = drive_q;
  assign tok_out     = tok_q;

  // R3: the line is only taken right after a token arrived
  a_r3_drive_needs_token: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_q) |-> $past(token_in));
  // R6: token pulse is one cycle wide
  a_r6_tok_pulse: assert property (@(posedge clk) disable iff (rst)
    tok_q |=> !tok_q);
  // R6: token never overlaps driving
  a_r6_tok_bus_free: assert property (@(posedge clk) disable iff (rst)
    tok_q |-> !drive_q);
  // R6: releasing the line is followed by the token
  a_r6_tok_follows: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_q) |=> tok_q);
  // R8: never more records than latched, latched never above the limit
  a_r8_sent_bound: assert property (@(posedge clk) disable iff (rst)
    (sent_q <= cnt_q) && (cnt_q <= CNT_W'(MAX_EV)));
  // R9: a token arriving mid-burst does not restart the burst
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND) && token_in && !word_end |=> $stable(sent_q));
endmodule

// File: rtl/tokring_readout.sv
module tokring_readout
  import tokring_pkg::*;
#(
  parameter int ID_W   = ID_BITS,
  parameter int MAX_EV = MAX_EVENTS,
  parameter int REC_W  = REC_BITS,
  localparam int CNT_W = $clog2(MAX_EV + 1),
  localparam int AW    = (MAX_EV > 1) ? $clog2(MAX_EV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             token_in,
  input  logic [ID_W-1:0]  node_id,
  input  logic [CNT_W-1:0] ev_count,
  output logic [AW-1:0]    rec_addr,
  input  logic [REC_W-1:0] rec_data,
  output logic             bus_data,
  output logic             bus_oe,
  output logic             xmit_busy,
  output logic             token_out
);
  localparam int HDR_W = ID_W + CNT_W;
  localparam int SW    = (REC_W > HDR_W) ? REC_W : HDR_W;
  localparam int LEN_W = $clog2(SW);

  logic             ld_header, ld_record, word_end, drive, msb;
  logic [CNT_W-1:0] cnt_latched, cnt_clamped;
  logic [SW-1:0]    hdr_word, ld_word;
  logic [LEN_W-1:0] ld_last;

  tokring_seq #(.MAX_EV(MAX_EV), .CNT_W(CNT_W), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .token_in(token_in), .ev_count(ev_count),
    .word_end(word_end), .ld_header(ld_header), .ld_record(ld_record),
    .cnt_latched(cnt_latched), .cnt_clamped(cnt_clamped),
    .rec_addr(rec_addr), .drive(drive), .tok_out(token_out));

  assign hdr_word = SW'({node_id, cnt_clamped}) << (SW - HDR_W);
  assign ld_word  = ld_header ? hdr_word : SW'(rec_data) << (SW - REC_W);
  assign ld_last  = ld_header ? LEN_W'(HDR_W - 1) : LEN_W'(REC_W - 1);

  tokring_shifter #(.SW(SW), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst(rst), .load(ld_header | ld_record), .load_word(ld_word),
    .load_last_idx(ld_last), .shift_en(drive), .msb(msb), .word_end(word_end));

  assign bus_data  = drive & msb;
  assign bus_oe    = drive;
  assign xmit_busy = drive;

  // R7: line is quiet when not driven
  a_r7_quiet_line: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> !bus_data);
  // R8: latched count is held for the whole burst
  a_r8_count_held: assert property (@(posedge clk) disable iff (rst)
    bus_oe && $past(bus_oe) |-> $stable(cnt_latched));
endmodule

// File: tb/tokring_readout_bench.sv
module tokring_readout_bench;
  import tokring_pkg::*;
  localparam int CNT_W = 5, AW = 4, RW = REC_BITS;

  logic clk = 0, rst = 1, token_in = 0;
  logic [7:0] node_id = 0;
  logic [CNT_W-1:0] ev_count = 0;
  logic [AW-1:0] rec_addr;
  logic [RW-1:0] rec_data;
  logic bus_data, bus_oe, xmit_busy, token_out;

  always #5 clk = ~clk;

  tokring_readout u_tokring_readout (.clk(clk), .rst(rst), .token_in(token_in),
    .node_id(node_id), .ev_count(ev_count), .rec_addr(rec_addr), .rec_data(rec_data),
    .bus_data(bus_data), .bus_oe(bus_oe), .xmit_busy(xmit_busy), .token_out(token_out));

  logic [RW-1:0] store [16];
  always_ff @(posedge clk) rec_data <= store[rec_addr];

  int checks = 0, fails = 0, cyc = 0;
  bit exp_q[$];
  int drive_cycles, tok_pulses, tok_cyc, last_hi;
  bit prev_tok;
  bit monitor_on = 0;

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (monitor_on) begin
    if (bus_oe) begin
      drive_cycles++;
      last_hi = cyc;
      if (exp_q.size() == 0) check(0, "R5 extra driven bit", 1, 0);
      else begin
        automatic bit e = exp_q.pop_front();
        check(bus_data == e, "R4 serial bit", bus_data, e);
      end
    end else begin
      check(bus_data == 0, "R7 idle line", bus_data, 0);
    end
    check(xmit_busy == bus_oe, "R5 busy flag", xmit_busy, bus_oe);
    if (token_out) begin
      tok_pulses++;
      tok_cyc = cyc;
      check(!bus_oe, "R6 token while driving", bus_oe, 0);
      check(!prev_tok, "R6 token width", 2, 1);
    end
    prev_tok = token_out;
  end

  function automatic event_rec_t make_rec(int seed, int i);
    event_rec_t r;
    r.coarse    = 8'(seed * 37 + i * 11);
    r.fine      = 12'(seed * 523 + i * 97 + 5);
    r.charge    = 12'(seed * 1931 ^ (i * 211));
    r.gain_sel  = 1'((seed + i) & 1);
    r.trig_stat = 1'((i * 3 + seed) >> 1);
    return r;
  endfunction

  task automatic push_bits(logic [RW-1:0] w, int n);
    for (int b = n - 1; b >= 0; b--) exp_q.push_back(w[b]);
  endtask

  // driver: one token turn
  task automatic turn(int id, int n, bit disturb);
    int eff = (n > 16) ? 16 : n;
    int t_in;
    node_id = 8'(id);
    ev_count = CNT_W'(n);
    for (int i = 0; i < 16; i++) store[i] = make_rec(id, i);
    if (eff > 0) begin
      push_bits(RW'({8'(id), CNT_W'(eff)}), 13);
      for (int i = 0; i < eff; i++) push_bits(store[i], RW);
    end
    drive_cycles = 0; tok_pulses = 0; tok_cyc = -1; last_hi = -1;
    @(negedge clk); token_in = 1; t_in = cyc;
    @(negedge clk); token_in = 0;
    if (disturb && eff > 0) begin
      repeat (20) @(negedge clk);
      ev_count = CNT_W'(n + 3);            // R8 change mid-burst
      token_in = 1;                        // R9 token while busy
      @(negedge clk); token_in = 0;
      ev_count = 0;
    end
    for (int k = 0; k < 700 && tok_pulses == 0; k++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(tok_pulses == 1, "R9 token pulse count", tok_pulses, 1);
    check(exp_q.size() == 0, "R4 missing bits", exp_q.size(), 0);
    exp_q.delete();
    if (eff == 0) begin
      check(tok_cyc == t_in + 1, "R2 immediate pass", tok_cyc, t_in + 1);
      check(drive_cycles == 0, "R2 no drive", drive_cycles, 0);
    end else begin
      check(drive_cycles == 13 + 34 * eff, "R5 burst length", drive_cycles, 13 + 34 * eff);
      check(last_hi - drive_cycles == t_in, "R3 burst start", last_hi - drive_cycles + 1, t_in + 1);
      check(tok_cyc == last_hi + 2, "R6 token after release", tok_cyc, last_hi + 2);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) store[i] = '0;
    repeat (3) @(negedge clk);
    check({bus_oe, xmit_busy, token_out, bus_data} == 0, "R1 in reset",
          {bus_oe, xmit_busy, token_out, bus_data}, 0);
    rst = 0;
    @(negedge clk);
    check({bus_oe, xmit_busy, token_out, bus_data} == 0, "R1 after reset",
          {bus_oe, xmit_busy, token_out, bus_data}, 0);
    monitor_on = 1;
    turn(8'h5A, 0, 0);   // R2 empty chip
    turn(8'hA5, 1, 0);   // R3 single record
    turn(8'hFF, 3, 0);   // R4 several records
    turn(8'h01, 16, 0);  // R4 full store
    turn(8'h3C, 20, 0);  // R8 clamp above limit
    turn(8'h81, 4, 1);   // R8, R9 disturbance mid-burst
    turn(8'h00, 0, 0);   // R2 again after bursts
    turn(8'h7E, 2, 1);   // R9 again
    monitor_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule